// File: doc/BRIEF.md
# ATM Transmit Cell FIFO

This block buffers ATM cells on their way from an ATM layer device to a transmission framer. The writer presents a cell one word per clock under a write strobe, with a start-of-cell marker on the first word and an odd-parity bit on every word. Storage is managed in whole cells. Up to sixteen cells fit in the physical store, and a 2-bit setting lowers the usable depth to twelve, eight or four cells. A cell-available output tells the writer whether another whole cell can be accepted at the selected depth.

The framer side sees a cell only after its last word has been stored. It then pulls the cell out one word per strobe, with first-word and last-word markers. A flush input empties the buffer without touching configuration or status. Three sticky event bits record parity errors, cells refused for lack of room and start-of-cell misalignment. A status read clears them, and each has its own interrupt enable feeding one interrupt output. A configuration bit can also make the block throw away any cell that carried a parity error.

Top module: `atm_tx_cell_fifo`

## Requirements
- R1: After a synchronous active-low reset, `cell_count` is 0, `cell_avail` is 1, `rd_cell_ready` is 0, and `st_perr`, `st_ovf`, `st_soc` and `irq` are 0.
- R2: The usable depth follows `cfg_depth_sel`: 00 gives 16 cells, 01 gives 12, 10 gives 8 and 11 gives 4. `cell_avail` is 1 exactly when `cell_count` is below that depth.
- R3: The number of words in a cell is 27 when `cfg_wide16`=1 and `cfg_cell52`=0, 26 when both are 1, 53 when both are 0, and 52 when `cfg_wide16`=0 and `cfg_cell52`=1. In 8-bit mode only `wr_data[7:0]` and `rd_data[7:0]` carry data.
- R4: A cell becomes visible on the read side (`rd_cell_ready`=1, `cell_count` incremented) on the clock edge that stores its last word, and not before. Cells come out in write order. `rd_first` marks word 0 and `rd_last` marks the final word, and each `rd_en` while ready advances one word.
- R5: A start-of-cell word that arrives while `cell_count` is at or above the selected depth causes the whole cell to be discarded and sets `st_ovf`. The stored cells stay unchanged.
- R6: Parity is odd: `^{wr_par, data}` must be 1, taken over `wr_data[7:0]` in 8-bit mode. Any written word that fails this sets `st_perr`. When `cfg_drop_perr`=1, a cell with any failing word is discarded. When it is 0, the cell is kept.
- R7: `wr_soc` on a word that is not the first of a cell sets `st_soc`, discards the partial cell and starts a new cell with that word. A word without `wr_soc` outside a cell sets `st_soc` and is discarded.
- R8: A one-cycle `sw_flush` empties the buffer, including any partial cell, so that `cell_count` is 0 on the next cycle. Status bits and configuration are kept.
- R9: The status bits are sticky. A `stat_rd` pulse clears all three, but an event in the same cycle as `stat_rd` leaves its bit set.
- R10: `irq` is 1 exactly when a status bit is set and its enable (`cfg_ie_perr`, `cfg_ie_ovf`, `cfg_ie_soc`) is 1.
- R11: `cell_count` equals the number of complete cells held. It rises by one per stored cell and falls by one per cell read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_depth_sel | input | 2 | Usable depth select |
| cfg_cell52 | input | 1 | 1: 52-byte cells, 0: 53-byte cells |
| cfg_wide16 | input | 1 | 1: 16-bit words, 0: 8-bit words |
| cfg_drop_perr | input | 1 | Discard cells that carried a parity error |
| cfg_ie_perr | input | 1 | Interrupt enable for parity status |
| cfg_ie_ovf | input | 1 | Interrupt enable for overflow status |
| cfg_ie_soc | input | 1 | Interrupt enable for misalignment status |
| sw_flush | input | 1 | Empty the buffer |
| stat_rd | input | 1 | Status read strobe, clears status |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | DATA_W | Write word |
| wr_par | input | 1 | Odd parity bit of the write word |
| wr_soc | input | 1 | Start-of-cell marker |
| cell_avail | output | 1 | Room for one more cell at the selected depth |
| cell_count | output | clog2(PHYS_CELLS+1) | Complete cells held |
| rd_cell_ready | output | 1 | A complete cell is readable |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_data | output | DATA_W | Read word |
| rd_first | output | 1 | Current read word is word 0 |
| rd_last | output | 1 | Current read word is the last of the cell |
| st_perr | output | 1 | Sticky parity error status |
| st_ovf | output | 1 | Sticky overflow status |
| st_soc | output | 1 | Sticky start-of-cell misalignment status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a cell that is refused, dropped or cut short while earlier cells are still in the store, because that is where a wrong pointer or count would corrupt the cells already held. The stimulus fills the store to each selected depth and pushes one extra cell. It restarts a cell halfway through and flushes in the middle of a cell, then reads every remaining cell back word by word. A seeded random phase interleaves writes, reads, parity faults and configuration changes across all four word layouts, and a bench model predicts the count, the status bits and the data of every read.

// File: rtl/atm_txf_pkg.sv
// Shared types for the transmit cell FIFO.
// Assumes: three event sources, handled alike by the status block.
package atm_txf_pkg;

    // One flag per status event source.
    typedef struct packed {
        logic perr;
        logic ovf;
        logic soc;
    } txf_evt_t;

endpackage

// File: rtl/atm_txf_wrside.sv
// Write-side controller: tracks the word position inside the cell being
// written. It checks odd parity, refuses cells when there is no room,
// realigns on a stray start-of-cell and decides whether a completed cell
// is committed.
// Assumes: cfg inputs are static while a cell is in flight; words >= 2.
module atm_txf_wrside
    import atm_txf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_par,
    input  logic              wr_soc,
    input  logic              wide16,
    input  logic              drop_perr,
    input  logic [IDX_W-1:0]  words,
    input  logic              room,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic              commit,
    output txf_evt_t          evt
);
    localparam int NARROW_W = DATA_W / 2;

    logic             in_cell;
    logic             drop_cell;
    logic             bad_cell;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] masked;
    logic             word_ok;
    logic             at_end;

    // Parity sees only the active lanes of the word.
    always_comb begin
        masked  = wide16 ? wr_data : {{(DATA_W-NARROW_W){1'b0}}, wr_data[NARROW_W-1:0]};
        word_ok = ^{wr_par, masked};
        at_end  = (idx == words - IDX_W'(1));
        mem_idx = wr_soc ? '0 : idx;
    end

    // Decides the store write, the commit and the event flags for this word.
    always_comb begin
        mem_we = 1'b0;
        commit = 1'b0;
        evt    = '0;
        if (wr_en && !flush) begin
            evt.perr = !word_ok;
            if (wr_soc) begin
                evt.soc = in_cell;
                evt.ovf = !room;
                mem_we  = room;
            end else if (!in_cell) begin
                evt.soc = 1'b1;
            end else begin
                mem_we = !drop_cell;
                if (at_end)
                    commit = !drop_cell && !(drop_perr && (bad_cell || !word_ok));
            end
        end
    end

    // Advances the position within the cell and accumulates its fault flags.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            in_cell   <= 1'b0;
            drop_cell <= 1'b0;
            bad_cell  <= 1'b0;
            idx       <= '0;
        end else if (wr_en) begin
            if (wr_soc) begin
                in_cell   <= 1'b1;
                drop_cell <= !room;
                bad_cell  <= !word_ok;
                idx       <= IDX_W'(1);
            end else if (in_cell) begin
                bad_cell <= bad_cell | !word_ok;
                if (at_end) begin
                    in_cell <= 1'b0;
                    idx     <= '0;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/atm_txf_store.sv
// Cell store: one slot of MAX_WORDS words per physical cell, a write slot
// pointer that moves on commit, and a read slot/word pointer. It also holds
// the count of complete cells.
// Assumes: the write side only writes into the write slot while the count
// is below PHYS_CELLS, so it never overwrites the slot being read.
module atm_txf_store #(
    parameter int DATA_W     = 16,
    parameter int PHYS_CELLS = 16,
    parameter int MAX_WORDS  = 53,
    parameter int IDX_W      = 6,
    parameter int CNT_W      = 5
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit,
    input  logic [IDX_W-1:0]  words,
    input  logic              rd_en,
    output logic [CNT_W-1:0]  count,
    output logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_first,
    output logic              rd_last
);
    localparam int SLOT_W = (PHYS_CELLS > 1) ? $clog2(PHYS_CELLS) : 1;
    localparam int DEPTH  = PHYS_CELLS * MAX_WORDS;
    localparam int ADDR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] rd_slot;
    logic [IDX_W-1:0]  rd_idx;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic              pop;

    function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] s);
        return (s == SLOT_W'(PHYS_CELLS - 1)) ? '0 : s + SLOT_W'(1);
    endfunction

    // Flat addresses of the word being written and the word being read.
    always_comb begin
        waddr    = ADDR_W'(int'(wr_slot) * MAX_WORDS + int'(widx));
        raddr    = ADDR_W'(int'(rd_slot) * MAX_WORDS + int'(rd_idx));
        rd_ready = (count != '0);
        rd_data  = mem[raddr];
        rd_first = (rd_idx == '0);
        rd_last  = (rd_idx == words - IDX_W'(1));
        pop      = rd_en && rd_ready && rd_last;
    end

    // Word storage, written without reset.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Slot pointers and the complete-cell count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_slot <= '0;
            rd_slot <= '0;
            rd_idx  <= '0;
            count   <= '0;
        end else begin
            if (commit)
                wr_slot <= slot_next(wr_slot);
            if (rd_en && rd_ready) begin
                if (rd_last) begin
                    rd_idx  <= '0;
                    rd_slot <= slot_next(rd_slot);
                end else begin
                    rd_idx <= rd_idx + IDX_W'(1);
                end
            end
            case ({commit, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/atm_txf_status.sv
// Sticky status bits with clear-on-read and a masked interrupt output.
// Assumes: an event in the same cycle as the read strobe survives the clear.
module atm_txf_status
    import atm_txf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stat_rd,
    input  txf_evt_t evt,
    input  txf_evt_t ien,
    output txf_evt_t st,
    output logic     irq
);
    // Sets on events, clears on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= '0;
        else
            st <= (stat_rd ? txf_evt_t'('0) : st) | evt;
    end

    // Interrupt is any enabled status bit.
    always_comb irq = |(st & ien);

endmodule

// File: rtl/atm_tx_cell_fifo.sv
// Transmit cell FIFO top: derives the words per cell and the usable depth
// from configuration, and wires the write controller, the cell store and
// the status block together.
// Assumes: configuration changes only while the buffer is empty and idle.
module atm_tx_cell_fifo
    import atm_txf_pkg::*;
#(
    parameter  int DATA_W     = 16,
    parameter  int PHYS_CELLS = 16,
    parameter  int CELL_BYTES = 53,
    localparam int CNT_W      = $clog2(PHYS_CELLS + 1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_depth_sel,
    input  logic              cfg_cell52,
    input  logic              cfg_wide16,
    input  logic              cfg_drop_perr,
    input  logic              cfg_ie_perr,
    input  logic              cfg_ie_ovf,
    input  logic              cfg_ie_soc,
    input  logic              sw_flush,
    input  logic              stat_rd,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_par,
    input  logic              wr_soc,
    output logic              cell_avail,
    output logic [CNT_W-1:0]  cell_count,
    output logic              rd_cell_ready,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_first,
    output logic              rd_last,
    output logic              st_perr,
    output logic              st_ovf,
    output logic              st_soc,
    output logic              irq
);
    localparam int MAX_WORDS = CELL_BYTES;
    localparam int IDX_W     = $clog2(MAX_WORDS + 1);
    localparam int STEP      = PHYS_CELLS / 4;

    logic [IDX_W-1:0] words_now;
    logic [CNT_W-1:0] depth_now;
    logic             room;
    logic             mem_we;
    logic [IDX_W-1:0] mem_idx;
    logic             commit;
    txf_evt_t         evt;
    txf_evt_t         ien;
    txf_evt_t         st;

    // Words per cell and usable depth from configuration.
    always_comb begin
        int bytes;
        bytes     = cfg_cell52 ? CELL_BYTES - 1 : CELL_BYTES;
        words_now = IDX_W'(cfg_wide16 ? (bytes + 1) / 2 : bytes);
        depth_now = CNT_W'(PHYS_CELLS - int'(cfg_depth_sel) * STEP);
        room      = (cell_count < depth_now);
        cell_avail = room;
        ien       = '{perr: cfg_ie_perr, ovf: cfg_ie_ovf, soc: cfg_ie_soc};
        st_perr   = st.perr;
        st_ovf    = st.ovf;
        st_soc    = st.soc;
    end

    atm_txf_wrside #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .flush(sw_flush),
        .wr_en(wr_en), .wr_data(wr_data), .wr_par(wr_par), .wr_soc(wr_soc),
        .wide16(cfg_wide16), .drop_perr(cfg_drop_perr), .words(words_now),
        .room(room), .mem_we(mem_we), .mem_idx(mem_idx), .commit(commit),
        .evt(evt)
    );

    atm_txf_store #(
        .DATA_W(DATA_W), .PHYS_CELLS(PHYS_CELLS), .MAX_WORDS(MAX_WORDS),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .flush(sw_flush),
        .we(mem_we), .widx(mem_idx), .wdata(wr_data), .commit(commit),
        .words(words_now), .rd_en(rd_en), .count(cell_count),
        .rd_ready(rd_cell_ready), .rd_data(rd_data),
        .rd_first(rd_first), .rd_last(rd_last)
    );

    atm_txf_status u_stat (
        .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd),
        .evt(evt), .ien(ien), .st(st), .irq(irq)
    );

endmodule

// File: rtl/atm_txf_chk.sv
// Property checker for the transmit cell FIFO, bound to the top module.
// Assumes: the depth select changes only while the buffer is empty.
module atm_txf_chk #(
    parameter int DATA_W     = 16,
    parameter int PHYS_CELLS = 16,
    parameter int CNT_W      = 5
)(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_depth_sel,
    input logic              cfg_wide16,
    input logic              sw_flush,
    input logic              stat_rd,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_par,
    input logic              wr_soc,
    input logic [CNT_W-1:0]  cell_count,
    input logic              rd_cell_ready,
    input logic              st_perr,
    input logic              st_ovf
);
    logic [CNT_W-1:0]  limit;
    logic [DATA_W-1:0] lanes;
    logic              armed;

    // Reference depth and parity lanes, computed apart from the design.
    always_comb begin
        case (cfg_depth_sel)
            2'd0:    limit = CNT_W'(PHYS_CELLS);
            2'd1:    limit = CNT_W'(PHYS_CELLS * 3 / 4);
            2'd2:    limit = CNT_W'(PHYS_CELLS / 2);
            default: limit = CNT_W'(PHYS_CELLS / 4);
        endcase
        lanes = cfg_wide16 ? wr_data : (wr_data & DATA_W'((1 << (DATA_W / 2)) - 1));
    end

    // Marks that a previous cycle out of reset exists.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cell_count <= limit);

    // R11
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(sw_flush)) |->
        (cell_count == $past(cell_count) ||
         cell_count == $past(cell_count) + CNT_W'(1) ||
         cell_count == $past(cell_count) - CNT_W'(1)));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_flush |=> (cell_count == '0 && !rd_cell_ready));

    // R5
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_soc && !sw_flush && cell_count >= limit) |=> st_ovf);

    // R6
    perr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sw_flush && !(^{wr_par, lanes})) |=> st_perr);

    // R9
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ovf && !stat_rd) |=> st_ovf);

    // R4
    ready_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cell_ready |-> (cell_count == '0));

endmodule

bind atm_tx_cell_fifo atm_txf_chk #(
    .DATA_W(DATA_W), .PHYS_CELLS(PHYS_CELLS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_depth_sel(cfg_depth_sel),
    .cfg_wide16(cfg_wide16), .sw_flush(sw_flush), .stat_rd(stat_rd),
    .wr_en(wr_en), .wr_data(wr_data), .wr_par(wr_par), .wr_soc(wr_soc),
    .cell_count(cell_count), .rd_cell_ready(rd_cell_ready),
    .st_perr(st_perr), .st_ovf(st_ovf)
);

// File: tb/sim_atm_tx_cell_fifo.sv
// Bench for the transmit cell FIFO: directed corner cases, then a seeded
// random phase, checked against a bench model of cells and status.
module sim_atm_tx_cell_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_depth_sel = 2'd0;
    logic        cfg_cell52 = 1'b0, cfg_wide16 = 1'b1, cfg_drop_perr = 1'b0;
    logic        cfg_ie_perr = 1'b0, cfg_ie_ovf = 1'b0, cfg_ie_soc = 1'b0;
    logic        sw_flush = 1'b0, stat_rd = 1'b0;
    logic        wr_en = 1'b0, wr_par = 1'b0, wr_soc = 1'b0;
    logic [15:0] wr_data = '0;
    logic        cell_avail, rd_cell_ready, rd_first, rd_last;
    logic        rd_en = 1'b0;
    logic [4:0]  cell_count;
    logic [15:0] rd_data;
    logic        st_perr, st_ovf, st_soc, irq;

    int total = 0;
    int bad = 0;
    int mcount = 0;
    bit m_perr = 0, m_ovf = 0, m_soc = 0;
    logic [15:0] expq[$];

    always #4 clk = ~clk;

    atm_tx_cell_fifo u0 (
        .clk(clk), .rst_n(rst_n), .cfg_depth_sel(cfg_depth_sel),
        .cfg_cell52(cfg_cell52), .cfg_wide16(cfg_wide16),
        .cfg_drop_perr(cfg_drop_perr), .cfg_ie_perr(cfg_ie_perr),
        .cfg_ie_ovf(cfg_ie_ovf), .cfg_ie_soc(cfg_ie_soc),
        .sw_flush(sw_flush), .stat_rd(stat_rd), .wr_en(wr_en),
        .wr_data(wr_data), .wr_par(wr_par), .wr_soc(wr_soc),
        .cell_avail(cell_avail), .cell_count(cell_count),
        .rd_cell_ready(rd_cell_ready), .rd_en(rd_en), .rd_data(rd_data),
        .rd_first(rd_first), .rd_last(rd_last), .st_perr(st_perr),
        .st_ovf(st_ovf), .st_soc(st_soc), .irq(irq)
    );

    function automatic int f_words(bit w, bit c52);
        int b = c52 ? 52 : 53;
        return w ? (b + 1) / 2 : b;
    endfunction

    function automatic int f_depth(logic [1:0] s);
        return 16 - 4 * int'(s);
    endfunction

    function automatic logic f_par(logic [15:0] d, bit w);
        logic [15:0] m = w ? d : {8'h00, d[7:0]};
        return ~(^m);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk(cell_count == mcount, {req, " count"}, cell_count, mcount);
        chk(cell_avail == (mcount < f_depth(cfg_depth_sel)), {req, " avail"},
            cell_avail, mcount < f_depth(cfg_depth_sel));
        chk(rd_cell_ready == (mcount != 0), {req, " ready"}, rd_cell_ready, mcount != 0);
    endtask

    task automatic check_status(input string req);
        chk({st_perr, st_ovf, st_soc} == {m_perr, m_ovf, m_soc}, {req, " status"},
            {st_perr, st_ovf, st_soc}, {m_perr, m_ovf, m_soc});
    endtask

    task automatic put_word(input logic [15:0] d, input logic p, input logic s);
        wr_data = d; wr_par = p; wr_soc = s; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_soc = 1'b0;
    endtask

    // Writes one whole cell; bad_at >= 0 corrupts parity of that word.
    task automatic send_cell(input int bad_at);
        logic [15:0] w[53];
        int n = f_words(cfg_wide16, cfg_cell52);
        bit accept = (mcount < f_depth(cfg_depth_sel));
        for (int i = 0; i < n; i++) begin
            w[i] = 16'($urandom);
            put_word(w[i], f_par(w[i], cfg_wide16) ^ (i == bad_at), i == 0);
        end
        if (!accept) m_ovf = 1;
        if (bad_at >= 0) m_perr = 1;
        if (accept && !(bad_at >= 0 && cfg_drop_perr)) begin
            for (int i = 0; i < n; i++) expq.push_back(w[i]);
            mcount++;
        end
    endtask

    // Reads one whole cell and compares every word and marker.
    task automatic recv_cell(input string req);
        int n = f_words(cfg_wide16, cfg_cell52);
        logic [15:0] mk = cfg_wide16 ? 16'hffff : 16'h00ff;
        bit ok = 1;
        logic [15:0] e;
        logic [15:0] a;
        chk(rd_cell_ready == 1'b1, {req, " ready before read"}, rd_cell_ready, 1);
        for (int i = 0; i < n; i++) begin
            e = expq.pop_front();
            a = rd_data;
            if ((a & mk) != (e & mk) || rd_first != (i == 0) || rd_last != (i == n - 1)) begin
                if (ok) chk(0, {req, " data/marker"}, a & mk, e & mk);
                ok = 0;
            end
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        if (ok) chk(1, req, 0, 0);
        mcount--;
    endtask

    task automatic do_flush();
        sw_flush = 1'b1;
        @(negedge clk);
        sw_flush = 1'b0;
        mcount = 0;
        expq.delete();
    endtask

    task automatic do_statrd();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        m_perr = 0; m_ovf = 0; m_soc = 0;
    endtask

    task automatic set_cfg(input logic [1:0] s, input bit w, input bit c52, input bit dp);
        cfg_depth_sel = s; cfg_wide16 = w; cfg_cell52 = c52; cfg_drop_perr = dp;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_state("R1");
        check_status("R1");
        chk(irq == 1'b0, "R1 irq", irq, 0);

        // R2, R11, R5, R4: fill to 16, then one cell too many
        for (int k = 0; k < 16; k++) begin
            send_cell(-1);
            check_state("R11 fill");
        end
        chk(cell_avail == 1'b0, "R2 full at 16", cell_avail, 0);
        send_cell(-1);
        check_state("R5 stored unchanged");
        check_status("R5 overflow");
        for (int k = 0; k < 16; k++) recv_cell("R4 in order");
        check_state("R11 drained");
        do_statrd();

        // R2: each reduced depth
        for (int s = 1; s < 4; s++) begin
            set_cfg(2'(s), 1, 0, 0);
            for (int k = 0; k < f_depth(2'(s)); k++) begin
                chk(cell_avail == 1'b1, "R2 room left", cell_avail, 1);
                send_cell(-1);
            end
            chk(cell_avail == 1'b0, "R2 at depth", cell_avail, 0);
            check_state("R2");
            do_flush();
            check_state("R8 flush empty");
        end

        // R8, R9: status survives flush, then set wins over clear
        send_cell(-1); send_cell(-1); send_cell(-1); send_cell(-1);
        send_cell(-1);
        do_flush();
        check_state("R8 after flush");
        check_status("R8 status kept");
        stat_rd = 1'b1;
        d = 16'h3c5a;
        put_word(d, ~f_par(d, 1), 1'b0);
        stat_rd = 1'b0;
        m_ovf = 0; m_perr = 1; m_soc = 1;
        check_status("R9 event beats clear");
        check_state("R7 stray word discarded");

        // R10: interrupt masking
        cfg_ie_ovf = 1'b1; @(negedge clk);
        chk(irq == 1'b0, "R10 ovf enable only", irq, 0);
        cfg_ie_ovf = 1'b0; cfg_ie_perr = 1'b1; @(negedge clk);
        chk(irq == 1'b1, "R10 perr enable", irq, 1);
        cfg_ie_perr = 1'b0; cfg_ie_soc = 1'b1; @(negedge clk);
        chk(irq == 1'b1, "R10 soc enable", irq, 1);
        do_statrd();
        check_status("R9 cleared");
        chk(irq == 1'b0, "R10 cleared", irq, 0);
        cfg_ie_soc = 1'b0;

        // R3, R4: every layout, cell invisible until its last word
        for (int c = 0; c < 4; c++) begin
            logic [15:0] w[53];
            int n;
            set_cfg(2'd0, c[0], c[1], 0);
            n = f_words(cfg_wide16, cfg_cell52);
            for (int i = 0; i < n - 1; i++) begin
                w[i] = 16'($urandom);
                put_word(w[i], f_par(w[i], cfg_wide16), i == 0);
            end
            chk(cell_count == 0 && rd_cell_ready == 1'b0, "R4 partial hidden", cell_count, 0);
            w[n-1] = 16'($urandom);
            put_word(w[n-1], f_par(w[n-1], cfg_wide16), 1'b0);
            chk(cell_count == 1, "R3 word count", cell_count, 1);
            for (int i = 0; i < n; i++) expq.push_back(w[i]);
            mcount = 1;
            recv_cell("R3 readback");
            check_status("R6 clean lanes");
        end

        // R6: parity keep vs drop
        set_cfg(2'd0, 1, 0, 0);
        send_cell(5);
        check_state("R6 kept");
        check_status("R6 flagged");
        recv_cell("R6 kept data");
        do_statrd();
        set_cfg(2'd0, 1, 0, 1);
        send_cell(3);
        check_state("R6 dropped");
        check_status("R6 flagged drop");
        do_statrd();

        // R7: restart mid-cell
        for (int i = 0; i < 5; i++) begin
            d = 16'($urandom);
            put_word(d, f_par(d, 1), i == 0);
        end
        send_cell(-1);
        m_soc = 1;
        check_state("R7 realigned");
        check_status("R7 misalign");
        recv_cell("R7 new cell data");
        do_statrd();

        // R8: flush mid-cell
        for (int i = 0; i < 10; i++) begin
            d = 16'($urandom);
            put_word(d, f_par(d, 1), i == 0);
        end
        do_flush();
        check_state("R8 partial gone");
        send_cell(-1);
        check_state("R8 fresh cell");
        recv_cell("R8 fresh data");
        check_status("R8 no events");

        // Random phase
        for (int it = 0; it < 300; it++) begin
            int r = int'($urandom_range(0, 9));
            if (it % 60 == 0) begin
                while (mcount > 0) recv_cell("R4 drain");
                do_flush();
                set_cfg(2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom));
            end
            if (r < 5)
                send_cell(($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 20)) : -1);
            else if (r < 9 && mcount > 0)
                recv_cell("R4 random read");
            else
                do_statrd();
            check_state("R11 random");
            check_status("R6 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule